// File: doc/BRIEF.md
# Latched 16-bit Pulse Counter

This block counts rising edges on an external pulse line in a 16-bit up-counter and exposes that counter to a processor through an 8-bit register port. The port has two locations: the live low byte and a single high-byte holding register. Each bus access moves only one byte. The holding register still makes whole-word transfers atomic, because every transfer between it and the live high byte happens as a side effect of a low-byte access.

To read, software reads the low byte first. That access snapshots the live high byte into the holding register, and a later high-byte read returns the snapshot. To write, software loads the holding register first. The low-byte write then updates all sixteen counter bits in one clock. A width input selects a narrow mode in which only the low byte counts. A sticky flag records wrap-around.

Top module: `latched_pulse_counter`

## Requirements
- R1: After reset the counter, the high-byte holding register, the read data output and the overflow flag are all zero.
- R2: The pulse input is synchronized through two flops. The counter advances by exactly one for each rising edge seen while `countEn` is high, however long the pulse stays high. Edges seen while `countEn` is low are not counted.
- R3: A read strobe with `busAddr`=0 puts the live low byte on `busRdData` in the cycle after the strobe. In the same clock it copies the live high byte into the holding register. Both values are the ones before any increment that lands in that clock.
- R4: A read strobe with `busAddr`=1 returns the holding register contents, not the live high byte. The value is stale if no low-byte read has refreshed it.
- R5: A write with `busAddr`=1 loads only the holding register and leaves the running counter unchanged.
- R6: In 16-bit mode (`wideMode`=1), a write with `busAddr`=0 loads the low byte from `busWrData` and the high byte from the holding register in the same clock.
- R7: A low-byte read issued between a high-byte write and the following low-byte write replaces the pending value. The counter then receives the high byte captured by that read.
- R8: With `wideMode`=0 only the low byte counts, wrapping from 0xFF to 0x00. The high byte holds its value, and a low-byte write changes only the low byte.
- R9: `ovfFlag` sets when a counted edge wraps the count to zero: from 0xFFFF in 16-bit mode, or from 0xFF in the low byte in 8-bit mode. It stays set until `ovfClear` is pulsed high.
- R10: When a low-byte write and a counted edge fall in the same clock, the written value is kept and that increment is lost.
- R11: When read and write strobes are high in the same cycle, only the write takes effect and `busRdData` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous pulse line to count |
| countEn | input | 1 | Counting enable |
| wideMode | input | 1 | 1 = 16-bit counting, 0 = 8-bit counting |
| busAddr | input | 1 | 0 = low byte, 1 = high-byte holding register |
| busWrData | input | 8 | Write data byte |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRdData | output | 8 | Registered read data, valid the cycle after `busRd` |
| ovfClear | input | 1 | Clears the overflow flag |
| ovfFlag | output | 1 | Sticky wrap indicator |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 16-bit counter and a two-stage synchronizer. Because counter values can be loaded through the bus, the 0xFFFF and 0xFF wrap points, and the 0x01FF carry into the high byte, are reached with a few pulses instead of tens of thousands. The three-register path from the pulse pin to the counter is short enough that a bus strobe can be placed in the exact clock where an increment lands. That exposes the pre-increment capture and the write-over-increment priority.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Bus address decode
  localparam logic ADDR_LOW  = 1'b0;
  localparam logic ADDR_HIGH = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic countStep;
    logic wrLow;
    logic wrHigh;
    logic rdLow;
    logic rdHigh;
  } ctrl_t;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  pulseIn,
  input  logic  countEn,
  input  logic  busAddr,
  input  logic  busRd,
  input  logic  busWr,
  output ctrl_t ctrl
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] syncChain;
  logic               riseSeen;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= pulseIn;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign riseSeen = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_comb begin
    ctrl           = '0;
    ctrl.countStep = riseSeen & countEn;
    // write strobe has priority over a simultaneous read
    ctrl.wrLow     = busWr & (busAddr == ADDR_LOW);
    ctrl.wrHigh    = busWr & (busAddr == ADDR_HIGH);
    ctrl.rdLow     = busRd & ~busWr & (busAddr == ADDR_LOW);
    ctrl.rdHigh    = busRd & ~busWr & (busAddr == ADDR_HIGH);
  end

  // R2: one edge gives one step, never two in a row
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.countStep |=> !ctrl.countStep);

  // R2: a step needs a synchronized high level just before it
  assert_step_from_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.countStep |=> syncChain[SYNC_STAGES]);
endmodule

// File: rtl/pcnt_datapath.sv
module pcnt_datapath
  import pcnt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              ovfClear,
  output logic [DATA_W-1:0] busRdData,
  output logic              ovfFlag
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] cntLo;
  logic [DATA_W-1:0] cntHi;
  logic [DATA_W-1:0] hiBuf;
  logic [CNT_W-1:0]  cntWide;
  logic [CNT_W-1:0]  cntWideNext;
  logic [DATA_W-1:0] cntLoNext;
  logic              stepTaken;
  logic              wrapHit;

  assign cntWide     = {cntHi, cntLo};
  assign cntWideNext = cntWide + CNT_W'(1);
  assign cntLoNext   = cntLo + DATA_W'(1);
  assign stepTaken   = ctrl.countStep & ~ctrl.wrLow;
  assign wrapHit     = stepTaken & (wideMode ? (&cntWide) : (&cntLo));

  // live counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (ctrl.wrLow) begin
      cntLo <= busWrData;
      if (wideMode) cntHi <= hiBuf;
    end else if (stepTaken) begin
      if (wideMode) begin
        cntLo <= cntWideNext[DATA_W-1:0];
        cntHi <= cntWideNext[CNT_W-1:DATA_W];
      end else begin
        cntLo <= cntLoNext;
      end
    end
  end

  // shared high-byte holding register
  always_ff @(posedge clk) begin
    if (!rstN)            hiBuf <= '0;
    else if (ctrl.wrHigh) hiBuf <= busWrData;
    else if (ctrl.rdLow)  hiBuf <= cntHi;
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (!rstN)            busRdData <= '0;
    else if (ctrl.rdLow)  busRdData <= cntLo;
    else if (ctrl.rdHigh) busRdData <= hiBuf;
  end

  // sticky overflow, set beats clear
  always_ff @(posedge clk) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (wrapHit) ovfFlag <= 1'b1;
    else if (ovfClear) ovfFlag <= 1'b0;
  end

  assert_rd_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdLow |=> (busRdData == $past(cntLo)) && (hiBuf == $past(cntHi)));

  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.wrHigh && !ctrl.rdLow) |=> $stable(hiBuf));

  assert_high_write_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrHigh && !ctrl.countStep) |=> ($stable(cntHi) && $stable(cntLo)));

  assert_low_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrLow && wideMode) |=> ({cntHi, cntLo} == {$past(hiBuf), $past(busWrData)}));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.countStep && !ctrl.wrLow && wideMode) |=>
      ({cntHi, cntLo} == CNT_W'($past({cntHi, cntLo}) + CNT_W'(1))));

  assert_narrow_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |=> $stable(cntHi));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag);

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(ctrl.countStep) && (cntLo == '0)));

  assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrLow && ctrl.countStep) |=> (cntLo == $past(busWrData)));

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.rdLow && !ctrl.rdHigh) |=> $stable(busRdData));
endmodule

// File: rtl/latched_pulse_counter.sv
module latched_pulse_counter
  import pcnt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              countEn,
  input  logic              wideMode,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData,
  input  logic              ovfClear,
  output logic              ovfFlag
);
  ctrl_t ctrl;

  pcnt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pulseIn (pulseIn),
    .countEn (countEn),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .ctrl    (ctrl)
  );

  pcnt_datapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wideMode  (wideMode),
    .busWrData (busWrData),
    .ovfClear  (ovfClear),
    .busRdData (busRdData),
    .ovfFlag   (ovfFlag)
  );
endmodule

// File: tb/tb_latched_pulse_counter.sv
module tb_latched_pulse_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic       countEn = 1'b1;
  logic       wideMode = 1'b1;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busRdData;
  logic       ovfClear = 1'b0;
  logic       ovfFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_pulse_counter dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .countEn(countEn),
    .wideMode(wideMode), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData),
    .ovfClear(ovfClear), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk); busAddr = addr; busWrData = data; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] data);
    @(negedge clk); busAddr = addr; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; data = busRdData;
  endtask

  task automatic readWord(output logic [15:0] w);
    logic [7:0] lo, hi;
    busRead(1'b0, lo);
    busRead(1'b1, hi);
    w = {hi, lo};
  endtask

  task automatic setWord(input logic [15:0] w);
    busWrite(1'b1, w[15:8]);
    busWrite(1'b0, w[7:0]);
  endtask

  task automatic pulse(input int highCycles);
    @(negedge clk); pulseIn = 1'b1;
    repeat (highCycles) @(negedge clk);
    pulseIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] w;
    chk("R1 rdData", {8'h0, busRdData}, 16'h0);
    chk("R1 ovf", {15'h0, ovfFlag}, 16'h0);
    busRead(1'b1, w[7:0]);
    chk("R1 buffer", {8'h0, w[7:0]}, 16'h0);
    readWord(w);
    chk("R1 counter", w, 16'h0);
  endtask

  task automatic testCount();
    logic [15:0] w;
    for (int i = 0; i < 5; i++) pulse(1 + i);
    readWord(w);
    chk("R2 five edges", w, 16'd5);
    countEn = 1'b0;
    pulse(2);
    countEn = 1'b1;
    readWord(w);
    chk("R2 disabled edge", w, 16'd5);
  endtask

  task automatic testWriteRead();
    logic [15:0] w;
    logic [7:0] b;
    setWord(16'h1234);
    readWord(w);
    chk("R6 word write", w, 16'h1234);
    busWrite(1'b1, 8'hAB);
    busRead(1'b0, b);
    chk("R5 live low unchanged", {8'h0, b}, 16'h0034);
    busRead(1'b1, b);
    chk("R5 live high unchanged", {8'h0, b}, 16'h0012);
    busWrite(1'b0, 8'h56);
    readWord(w);
    chk("R7 pending overwritten", w, 16'h1256);
    busWrite(1'b1, 8'h77);
    busRead(1'b1, b);
    chk("R4 stale buffer", {8'h0, b}, 16'h0077);
    setWord(16'h1256);
  endtask

  task automatic testCaptureRace();
    logic [7:0] b;
    setWord(16'h01FF);
    @(negedge clk); pulseIn = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 1'b0; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; pulseIn = 1'b0;
    chk("R3 low before increment", {8'h0, busRdData}, 16'h00FF);
    busRead(1'b1, b);
    chk("R3 high before increment", {8'h0, b}, 16'h0001);
    repeat (3) @(negedge clk);
    busRead(1'b0, b);
    chk("R3 low after carry", {8'h0, b}, 16'h0000);
    busRead(1'b1, b);
    chk("R3 high after carry", {8'h0, b}, 16'h0002);
  endtask

  task automatic testWriteWins();
    logic [15:0] w;
    busWrite(1'b1, 8'h00);
    @(negedge clk); pulseIn = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 1'b0; busWrData = 8'h40; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0; pulseIn = 1'b0;
    repeat (3) @(negedge clk);
    readWord(w);
    chk("R10 write beats edge", w, 16'h0040);
  endtask

  task automatic testOverflow();
    logic [15:0] w;
    setWord(16'hFFFF);
    chk("R9 ovf clear before wrap", {15'h0, ovfFlag}, 16'h0);
    pulse(1);
    chk("R9 ovf set on 16-bit wrap", {15'h0, ovfFlag}, 16'h1);
    readWord(w);
    chk("R9 counter wrapped", w, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R9 ovf sticky", {15'h0, ovfFlag}, 16'h1);
    @(negedge clk); ovfClear = 1'b1;
    @(negedge clk); ovfClear = 1'b0;
    chk("R9 ovf cleared", {15'h0, ovfFlag}, 16'h0);
  endtask

  task automatic testNarrow();
    logic [15:0] w;
    setWord(16'h5AFE);
    wideMode = 1'b0;
    pulse(1);
    pulse(1);
    readWord(w);
    chk("R8 low wraps, high held", w, 16'h5A00);
    chk("R9 ovf on 8-bit wrap", {15'h0, ovfFlag}, 16'h1);
    busWrite(1'b1, 8'h33);
    busWrite(1'b0, 8'h10);
    readWord(w);
    chk("R8 narrow write low only", w, 16'h5A10);
    wideMode = 1'b1;
    @(negedge clk); ovfClear = 1'b1;
    @(negedge clk); ovfClear = 1'b0;
  endtask

  task automatic testRdWrCollide();
    logic [15:0] w;
    logic [7:0] prev;
    setWord(16'h2211);
    busRead(1'b0, prev);
    @(negedge clk); busAddr = 1'b0; busWrData = 8'h99; busRd = 1'b1; busWr = 1'b1;
    @(negedge clk); busRd = 1'b0; busWr = 1'b0;
    chk("R11 rdData held", {8'h0, busRdData}, {8'h0, prev});
    readWord(w);
    chk("R11 write applied", w, 16'h2299);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCount();
    testWriteRead();
    testCaptureRace();
    testWriteWins();
    testOverflow();
    testNarrow();
    testRdWrCollide();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule